// File: doc/BRIEF.md
# Largest-Deficit Head Cache Replenisher

This block keeps the bookkeeping for the egress head cache of a hybrid packet buffer. The fast on-chip memory holds the first cells of each of `NQ` logical FIFOs, and the bulk memory holds the rest. For every queue the block tracks two counts: how many cells sit in the head cache (occupancy), and how many cells that queue still has in bulk memory. An external arbiter grants one cell read per cycle to a queue of its choosing, and the order of these grants cannot be predicted. Whenever the ingress side writes a block of `BLK` cells for a queue into bulk memory, it tells the block through the fill input.

One bulk-memory access fits in every `BLK` cycles. At each such slot the block looks for the queue with the most urgent need, and asks for that queue's next block of `BLK` cells to be moved into the head cache. A queue is *active* while its bulk-memory count is non-zero. The deficit of an active queue is `THRESH` minus its occupancy, floored at zero. An inactive queue has a deficit of zero. Every active queue is a candidate, however full its head cache is; no low-water trigger gates the choice. A head cache of at least `BLK*(2+ln NQ)` cells per queue is enough for reads never to stall. `CAP` is the per-queue capacity. Two sticky flags report a read from an empty head cache, and a fetch that would overrun `CAP`.

The fetch request is a valid/ready stream toward the bulk-memory controller. Once raised, `fetch_valid` and `fetch_qid` hold steady until `fetch_ready` is seen high at a clock edge, and that edge is the transfer. Back-pressure only delays the transfer. While a request is waiting, any slot that comes up is skipped. Read grants and fill notices have no ready signal and are always taken.

Top module: `ldf_head_refill`

## Requirements
- R1: After reset (asynchronous, active-low `rst_n`) every occupancy and bulk-memory count is zero, `q_active` is all zero, `fetch_valid` is low, and both error flags are low.
- R2: A fill notice for queue q adds `BLK` to that queue's bulk-memory count. `q_active[q]` is high exactly while that count is non-zero.
- R3: A read grant to queue q with non-zero occupancy lowers that occupancy by one at the next edge. Read grants are always accepted.
- R4: Slot cycles are the first cycle after reset and every `BLK`-th cycle after it. In a slot cycle with no request outstanding and a non-zero largest deficit, `fetch_valid` rises in the next cycle with `fetch_qid` naming the queue with the largest deficit (`THRESH - occupancy` for active queues with occupancy below `THRESH`, otherwise 0).
- R5: When several queues share the largest deficit, the lowest queue index is chosen.
- R6: No request is raised in a slot where every deficit is zero, or while an earlier request is still outstanding.
- R7: While `fetch_valid` is high and `fetch_ready` is low, `fetch_valid` and `fetch_qid` keep their values.
- R8: On a fetch transfer (`fetch_valid && fetch_ready`) the named queue's occupancy rises by `BLK` and its bulk-memory count falls by `BLK`. A read to the same queue in the same cycle is applied as well, giving a net change of `BLK-1`.
- R9: A read grant to a queue with zero occupancy sets `err_underflow`, which stays set until reset. That queue's occupancy stays zero.
- R10: If a transfer would raise an occupancy above `CAP`, the occupancy is held at `CAP`, and `err_overflow` is set and stays set until reset.
- R11: `q_occ` carries queue i's occupancy in bits `[i*OW +: OW]`, where `OW = ceil(log2(CAP+BLK+1))`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | A cell read is granted this cycle |
| rd_qid | input | QW = ceil(log2 NQ) | Queue of the granted read |
| fill_valid | input | 1 | A block of BLK cells was written to bulk memory |
| fill_qid | input | QW | Queue of that block |
| fetch_valid | output | 1 | Request to move BLK cells into the head cache |
| fetch_qid | output | QW | Queue the request is for |
| fetch_ready | input | 1 | Bulk-memory side accepts the request |
| q_occ | output | NQ*OW | Per-queue head-cache occupancy |
| q_active | output | NQ | Per-queue flag: cells remain in bulk memory |
| err_underflow | output | 1 | Sticky: read from an empty head cache |
| err_overflow | output | 1 | Sticky: a transfer exceeded CAP |

## Verification
The selection logic is first run with no active queue, which must produce silence. Two queues are then filled with equal deficits just after a slot, which separates lowest-index tie-breaking from first-come order. A long run follows with random reads, random fills and `fetch_ready` low about a quarter of the time. Against a cycle-level reference this tells a largest-deficit choice apart from round-robin or first-active choices. The same run shows whether skipped slots and held requests are handled, and whether a transfer and a read landing on the same queue in one cycle combine correctly. A final directed pass after a fresh reset drives one queue to its threshold, then drains two cells so that a small-deficit fetch overruns the capacity. Before that it reads an empty queue, so that each sticky flag is seen to rise from a known clear state.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

  // Width of an index over n items (at least one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter able to hold the value maxv.
  function automatic int cnt_w(input int maxv);
    return (maxv > 0) ? $clog2(maxv + 1) : 1;
  endfunction

endpackage

// File: rtl/ldf_queue_bank.sv
module ldf_queue_bank #(
  parameter int NQ     = 8,
  parameter int BLK    = 4,
  parameter int CAP    = 19,
  parameter int THRESH = 16,
  parameter int DCW    = 12,
  localparam int QW    = ldf_pkg::idx_w(NQ),
  localparam int OW    = ldf_pkg::cnt_w(CAP + BLK),
  localparam int DFW   = ldf_pkg::cnt_w(THRESH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [QW-1:0]     rd_qid,
  input  logic              fill_valid,
  input  logic [QW-1:0]     fill_qid,
  input  logic              xfer,
  input  logic [QW-1:0]     xfer_qid,
  output logic [NQ*OW-1:0]  occ_flat,
  output logic [NQ-1:0]     active,
  output logic [NQ*DFW-1:0] def_flat,
  output logic              uf_evt,
  output logic              of_evt
);

  localparam int SW = OW + 1;

  logic [NQ-1:0] uf_vec;
  logic [NQ-1:0] of_vec;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [OW-1:0]  occ_r;
    logic [DCW-1:0] dram_r;
    logic [DCW-1:0] dram_nx;
    logic [SW-1:0]  sum;
    logic           hit_rd;
    logic           hit_fill;
    logic           hit_xfer;
    logic           over;

    always_comb begin
      hit_rd   = rd_valid   && (rd_qid   == QW'(g));
      hit_fill = fill_valid && (fill_qid == QW'(g));
      hit_xfer = xfer       && (xfer_qid == QW'(g));
      sum = SW'(occ_r);
      if (hit_xfer)                 sum = sum + SW'(BLK);
      if (hit_rd && occ_r != '0)    sum = sum - SW'(1);
      over = (sum > SW'(CAP));
      dram_nx = dram_r;
      if (hit_fill) dram_nx = dram_nx + DCW'(BLK);
      if (hit_xfer) dram_nx = dram_nx - DCW'(BLK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_r  <= '0;
        dram_r <= '0;
      end else begin
        occ_r  <= over ? OW'(CAP) : sum[OW-1:0];
        dram_r <= dram_nx;
      end
    end

    assign active[g]                = (dram_r != '0);
    assign occ_flat[g*OW +: OW]     = occ_r;
    assign def_flat[g*DFW +: DFW]   = (active[g] && occ_r < OW'(THRESH))
                                      ? (DFW'(THRESH) - DFW'(occ_r)) : '0;
    assign uf_vec[g]                = hit_rd && (occ_r == '0);
    assign of_vec[g]                = hit_xfer && over;
  end

  assign uf_evt = |uf_vec;
  assign of_evt = |of_vec;

endmodule

// File: rtl/ldf_argmax.sv
module ldf_argmax #(
  parameter int NQ   = 8,
  parameter int DFW  = 5,
  localparam int QW  = ldf_pkg::idx_w(NQ),
  localparam int P   = 1 << QW
) (
  input  logic [NQ*DFW-1:0] def_flat,
  output logic [QW-1:0]     best_qid,
  output logic [DFW-1:0]    best_def
);

  // Heap-ordered tree: node 1 is the root, leaves sit at P..2P-1.
  logic [DFW-1:0] nd [1:2*P-1];
  logic [QW-1:0]  ni [1:2*P-1];

  for (genvar l = 0; l < P; l++) begin : g_leaf
    if (l < NQ) begin : g_real
      assign nd[P+l] = def_flat[l*DFW +: DFW];
    end else begin : g_pad
      assign nd[P+l] = '0;
    end
    assign ni[P+l] = QW'(l);
  end

  // The left child always covers lower indices, so it wins ties.
  for (genvar i = 1; i < P; i++) begin : g_node
    logic pick_r;
    assign pick_r = nd[2*i+1] > nd[2*i];
    assign nd[i]  = pick_r ? nd[2*i+1] : nd[2*i];
    assign ni[i]  = pick_r ? ni[2*i+1] : ni[2*i];
  end

  assign best_def = nd[1];
  assign best_qid = ni[1];

endmodule

// File: rtl/ldf_slot_ctrl.sv
module ldf_slot_ctrl #(
  parameter int NQ   = 8,
  parameter int BLK  = 4,
  parameter int DFW  = 5,
  localparam int QW  = ldf_pkg::idx_w(NQ),
  localparam int SLW = ldf_pkg::idx_w(BLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QW-1:0]  best_qid,
  input  logic [DFW-1:0] best_def,
  input  logic           fetch_ready,
  output logic           fetch_valid,
  output logic [QW-1:0]  fetch_qid,
  output logic           xfer
);

  logic slot_tick;

  if (BLK > 1) begin : g_cnt
    logic [SLW-1:0] slot_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_cnt <= '0;
      else if (slot_cnt == SLW'(BLK - 1))  slot_cnt <= '0;
      else                                 slot_cnt <= slot_cnt + SLW'(1);
    end
    assign slot_tick = (slot_cnt == '0);
  end else begin : g_every
    assign slot_tick = 1'b1;
  end

  assign xfer = fetch_valid && fetch_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      fetch_qid   <= '0;
    end else if (fetch_valid) begin
      if (fetch_ready) fetch_valid <= 1'b0;
    end else if (slot_tick && best_def != '0) begin
      fetch_valid <= 1'b1;
      fetch_qid   <= best_qid;
    end
  end

endmodule

// File: rtl/ldf_head_refill.sv
module ldf_head_refill #(
  parameter int NQ     = 8,
  parameter int BLK    = 4,
  parameter int CAP    = 19,
  parameter int THRESH = 16,
  parameter int DCW    = 12,
  localparam int QW    = ldf_pkg::idx_w(NQ),
  localparam int OW    = ldf_pkg::cnt_w(CAP + BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [QW-1:0]    rd_qid,
  input  logic             fill_valid,
  input  logic [QW-1:0]    fill_qid,
  output logic             fetch_valid,
  output logic [QW-1:0]    fetch_qid,
  input  logic             fetch_ready,
  output logic [NQ*OW-1:0] q_occ,
  output logic [NQ-1:0]    q_active,
  output logic             err_underflow,
  output logic             err_overflow
);

  localparam int DFW = ldf_pkg::cnt_w(THRESH);

  logic [NQ*DFW-1:0] def_flat;
  logic [QW-1:0]     best_qid;
  logic [DFW-1:0]    best_def;
  logic              xfer;
  logic              uf_evt;
  logic              of_evt;

  ldf_queue_bank #(
    .NQ(NQ), .BLK(BLK), .CAP(CAP), .THRESH(THRESH), .DCW(DCW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_qid(rd_qid),
    .fill_valid(fill_valid), .fill_qid(fill_qid),
    .xfer(xfer), .xfer_qid(fetch_qid),
    .occ_flat(q_occ), .active(q_active), .def_flat(def_flat),
    .uf_evt(uf_evt), .of_evt(of_evt)
  );

  ldf_argmax #(.NQ(NQ), .DFW(DFW)) u_max (
    .def_flat(def_flat), .best_qid(best_qid), .best_def(best_def)
  );

  ldf_slot_ctrl #(.NQ(NQ), .BLK(BLK), .DFW(DFW)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .best_qid(best_qid), .best_def(best_def),
    .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_qid(fetch_qid), .xfer(xfer)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
    end else begin
      err_underflow <= err_underflow | uf_evt;
      err_overflow  <= err_overflow  | of_evt;
    end
  end

endmodule

// File: rtl/ldf_refill_checker.sv
module ldf_refill_checker #(
  parameter int NQ     = 8,
  parameter int BLK    = 4,
  parameter int CAP    = 19,
  parameter int THRESH = 16,
  parameter int DCW    = 12,
  localparam int QW    = ldf_pkg::idx_w(NQ),
  localparam int OW    = ldf_pkg::cnt_w(CAP + BLK),
  localparam int SLW   = ldf_pkg::idx_w(BLK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic [QW-1:0]    rd_qid,
  input logic             fill_valid,
  input logic [QW-1:0]    fill_qid,
  input logic             fetch_valid,
  input logic [QW-1:0]    fetch_qid,
  input logic             fetch_ready,
  input logic [NQ*OW-1:0] q_occ,
  input logic             err_underflow,
  input logic             err_overflow,
  input logic [NQ-1:0]    q_active
);

  localparam logic [SLW-1:0] AFTER_SLOT = (BLK > 1) ? SLW'(1) : SLW'(0);

  function automatic logic [OW-1:0] occ_of(input logic [QW-1:0] q);
    return q_occ[int'(q)*OW +: OW];
  endfunction

  logic [OW-1:0]  rd_occ;
  logic           dec_pend;
  logic [QW-1:0]  dec_q;
  logic [OW-1:0]  dec_val;
  logic           fill_pend;
  logic [QW-1:0]  fill_q;
  logic [SLW-1:0] ck;

  assign rd_occ = occ_of(rd_qid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_pend  <= 1'b0;
      dec_q     <= '0;
      dec_val   <= '0;
      fill_pend <= 1'b0;
      fill_q    <= '0;
      ck        <= '0;
    end else begin
      dec_pend  <= rd_valid && rd_occ != '0 &&
                   !(fetch_valid && fetch_ready && fetch_qid == rd_qid);
      dec_q     <= rd_qid;
      dec_val   <= rd_occ - OW'(1);
      fill_pend <= fill_valid;
      fill_q    <= fill_qid;
      ck        <= (ck == SLW'(BLK - 1)) ? '0 : ck + SLW'(1);
    end
  end

  p_read_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pend |-> occ_of(dec_q) == dec_val);

  p_fill_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend |-> q_active[fill_q]);

  p_req_on_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> ck == AFTER_SLOT);

  p_req_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> q_active[fetch_qid]);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_qid));

  p_uf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_occ == '0 |=> err_underflow);

  p_uf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  p_of_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);

endmodule

bind ldf_head_refill ldf_refill_checker #(
  .NQ(NQ), .BLK(BLK), .CAP(CAP), .THRESH(THRESH), .DCW(DCW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_qid(rd_qid),
  .fill_valid(fill_valid), .fill_qid(fill_qid),
  .fetch_valid(fetch_valid), .fetch_qid(fetch_qid), .fetch_ready(fetch_ready),
  .q_occ(q_occ), .err_underflow(err_underflow), .err_overflow(err_overflow),
  .q_active(q_active)
);

// File: tb/test_ldf_head_refill.sv
`timescale 1ns/1ps
module test_ldf_head_refill;

  localparam int NQ = 8, BLK = 4, CAP = 17, THRESH = 16, DCW = 12;
  localparam int QW = $clog2(NQ);
  localparam int OW = $clog2(CAP + BLK + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0, fill_valid = 1'b0, fetch_ready = 1'b0;
  logic [QW-1:0] rd_qid = '0, fill_qid = '0;
  logic fetch_valid, err_underflow, err_overflow;
  logic [QW-1:0] fetch_qid;
  logic [NQ*OW-1:0] q_occ;
  logic [NQ-1:0] q_active;

  always #10 clk = ~clk;

  ldf_head_refill #(.NQ(NQ), .BLK(BLK), .CAP(CAP), .THRESH(THRESH), .DCW(DCW))
  i_ldf_head_refill (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_qid(rd_qid),
    .fill_valid(fill_valid), .fill_qid(fill_qid),
    .fetch_valid(fetch_valid), .fetch_qid(fetch_qid), .fetch_ready(fetch_ready),
    .q_occ(q_occ), .q_active(q_active),
    .err_underflow(err_underflow), .err_overflow(err_overflow)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural reference model
  int m_occ[NQ], m_dram[NQ], nxt[NQ];
  int m_rq, m_slot, best, bdef, d, o;
  bit m_rv, m_uf, m_of, hs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin m_occ[q] = 0; m_dram[q] = 0; end
      m_rv = 0; m_rq = 0; m_slot = 0; m_uf = 0; m_of = 0;
    end else begin
      hs = m_rv && fetch_ready;
      bdef = 0; best = 0;
      for (int q = 0; q < NQ; q++) begin
        d = (m_dram[q] > 0 && m_occ[q] < THRESH) ? THRESH - m_occ[q] : 0;
        if (d > bdef) begin bdef = d; best = q; end
      end
      if (rd_valid && m_occ[int'(rd_qid)] == 0) m_uf = 1;
      for (int q = 0; q < NQ; q++) begin
        o = m_occ[q];
        if (hs && q == m_rq) o = o + BLK;
        if (rd_valid && q == int'(rd_qid) && m_occ[q] > 0) o = o - 1;
        if (o > CAP) begin o = CAP; m_of = 1; end
        nxt[q] = o;
      end
      for (int q = 0; q < NQ; q++) m_occ[q] = nxt[q];
      if (hs) m_dram[m_rq] = m_dram[m_rq] - BLK;
      if (fill_valid) m_dram[int'(fill_qid)] = m_dram[int'(fill_qid)] + BLK;
      if (m_rv) begin
        if (hs) m_rv = 0;
      end else if (m_slot == 0 && bdef > 0) begin
        m_rv = 1; m_rq = best;
      end
      m_slot = (m_slot + 1) % BLK;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int occ_out(input int q);
    return int'(q_occ[q*OW +: OW]);
  endfunction

  task automatic compare_all();
    for (int q = 0; q < NQ; q++) begin
      chk($sformatf("R3 R8 R11 occupancy q%0d", q), occ_out(q), m_occ[q]);
      chk($sformatf("R2 active q%0d", q), int'(q_active[q]), (m_dram[q] > 0) ? 1 : 0);
    end
    chk("R4 R6 fetch_valid", int'(fetch_valid), int'(m_rv));
    if (m_rv) chk("R4 R5 fetch_qid", int'(fetch_qid), m_rq);
    chk("R9 err_underflow", int'(err_underflow), int'(m_uf));
    chk("R10 err_overflow", int'(err_overflow), int'(m_of));
  endtask

  // One cycle: compare at the falling edge, then clear the one-shot inputs.
  task automatic cyc();
    @(negedge clk);
    compare_all();
    rd_valid = 1'b0;
    fill_valid = 1'b0;
  endtask

  initial begin : main
    int q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 fetch_valid", int'(fetch_valid), 0);
    chk("R1 occupancy", int'(q_occ), 0);
    chk("R1 active", int'(q_active), 0);
    chk("R1 flags", int'({err_underflow, err_overflow}), 0);
    // R6: no active queue -> no request over two slots
    for (int i = 0; i < 2 * BLK; i++) begin
      cyc();
      chk("R6 idle fetch_valid", int'(fetch_valid), 0);
    end
    // R5: equal deficits on q5 and q2, q5 filled first
    while (m_slot != 1) cyc();
    fill_valid = 1'b1; fill_qid = QW'(5);
    cyc();
    fill_valid = 1'b1; fill_qid = QW'(2);
    for (int i = 0; i < 8 && !fetch_valid; i++) cyc();
    chk("R5 tie goes to lowest index", int'(fetch_qid), 2);
    // R7: hold under back-pressure
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R7 held valid", int'(fetch_valid), 1);
      chk("R7 held qid", int'(fetch_qid), 2);
    end
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      fetch_ready = ($urandom % 4) != 0;
      q = int'($urandom % NQ);
      if (($urandom % 4) != 0 && m_occ[q] > 0) begin
        rd_valid = 1'b1; rd_qid = QW'(q);
      end
      q = int'($urandom % NQ);
      if (($urandom % 6) == 0 && m_dram[q] < 12) begin
        fill_valid = 1'b1; fill_qid = QW'(q);
      end
      cyc();
    end
    // Fresh reset for the sticky-flag scenarios
    rst_n = 1'b0; fetch_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    rd_valid = 1'b1; rd_qid = QW'(7);
    cyc();
    chk("R9 underflow set", int'(err_underflow), 1);
    chk("R9 occupancy stays zero", occ_out(7), 0);
    for (int i = 0; i < 5; i++) begin
      fill_valid = 1'b1; fill_qid = QW'(0);
      cyc();
    end
    repeat (40) cyc();
    chk("R8 refilled to threshold", occ_out(0), 16);
    chk("R10 no overflow yet", int'(err_overflow), 0);
    chk("R2 still active", int'(q_active[0]), 1);
    rd_valid = 1'b1; rd_qid = QW'(0);
    cyc();
    rd_valid = 1'b1; rd_qid = QW'(0);
    repeat (20) cyc();
    chk("R10 overflow set", int'(err_overflow), 1);
    chk("R10 occupancy clipped", occ_out(0), CAP);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule